// File: doc/BRIEF.md
# Redundant-Digit Correction for a 1.5-Bit-per-Stage Pipeline Converter

This block sits behind the analog stages of a pipelined converter. Each analog stage resolves a three-level digit: it compares its input with two thresholds a quarter of the reference above and below mid-scale. It then hands a doubled residue to the next stage, after adding the reference, subtracting it, or doing neither. Neighbouring stages work on alternating clock phases, so on any one clock each stage holds a decision for a different sample. A small flash quantizer resolves the last residue. The block takes those staggered decisions, lines up every digit that belongs to one sample, and adds them. Each digit overlaps its neighbour by one bit, so a comparator that decides on the wrong side of its threshold is absorbed by the following stages.

With `NSTG` stages and an `FLW`-bit flash, the result has `NSTG+FLW` bits. A valid flag enters with the first stage's decision and comes out with the finished word.

Top module: `pipe_corr`

## Requirements
- R1: While rst_n is low and on the first clock after it rises, out_vld, out_bad and out_code are all 0.
- R2: out_vld equals in_vld as it was NSTG+1 clock edges earlier. The result for a sample whose first-stage decision was captured at edge e appears after edge e+NSTG.
- R3: For one sample, the decision of stage i (slice stg_dig[2i+1:2i], stage 0 first) is captured i edges after the stage-0 decision. The flash code is captured NSTG edges after it. Digits of different samples presented on the same edge are never mixed.
- R4: Digit codes are 2'b00 (below the lower threshold), 2'b01 (between the thresholds) and 2'b10 (above the upper threshold), with values 0, 1 and 2. The result is fl_code plus the sum over i of value_i times 2^(NSTG+FLW-2-i).
- R5: With ideal stages the result equals floor((vin+Vref)·2^(NSTG+FLW)/(2·Vref)). The result does not change when every stage threshold is moved by any amount smaller than Vref/4 in either direction, with the flash kept ideal.
- R6: Code 2'b11 on any stage marks that sample illegal, and out_bad is 1 together with its out_vld. The code 2'b11 enters the sum with value 3. Legal samples give out_bad 0.
- R7: The sum never wraps. A sum above 2^(NSTG+FLW)-1 gives out_code all ones, and the all-zero digits with flash 0 give all zeros.
- R8: While out_vld is 0, out_bad is 0 and out_code keeps the most recent valid result (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Stage-0 decision on this edge starts a sample |
| stg_dig | input | 2*NSTG | Current decision of each stage, two bits per stage, stage 0 in the low bits |
| fl_code | input | FLW | Final flash code for the sample entered NSTG edges earlier |
| out_vld | output | 1 | out_code holds a new result |
| out_code | output | NSTG+FLW | Corrected binary code |
| out_bad | output | 1 | The sample carried an illegal digit |

## Verification
The checker watches on every cycle that out_vld trails in_vld by exactly NSTG+1 edges. It also checks that a first-stage 2'b11 always raises out_bad at that sample's output, that out_bad never appears without out_vld, and that out_code stays put while out_vld is low. The correctness of the sum depends on the digits lining up across stages and on the one-bit overlap. Only the bench's scenarios show those, together with the immunity to threshold offsets and the clamp at all ones. The bench drives a behavioural stage model across a sweep of the input range, both with ideal thresholds and with shifted ones, and inserts idle slots. It also drives hand-built digit patterns for the weights, the illegal code and the extremes of the range.

// File: rtl/pc_pkg.sv
package pc_pkg;

    typedef enum logic [1:0] {
        DIG_LO  = 2'b00,
        DIG_MID = 2'b01,
        DIG_HI  = 2'b10,
        DIG_BAD = 2'b11
    } pc_dig_e;

    function automatic logic dig_is_bad(input logic [1:0] d);
        return d == DIG_BAD;
    endfunction

endpackage

// File: rtl/pc_delay.sv
module pc_delay #(
    parameter int W     = 2,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [DEPTH-1:0][W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d[0] = din;
        for (int j = 1; j < DEPTH; j++) begin
            sr_d[j] = sr_q[j-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign dout = sr_q[DEPTH-1];
endmodule

// File: rtl/pc_sum.sv
module pc_sum #(
    parameter int K  = 6,
    parameter int FW = 2,
    localparam int OW = K + FW,
    localparam int AW = OW + 2
) (
    input  logic [2*K-1:0] dig,
    input  logic [FW-1:0]  fl,
    output logic [OW-1:0]  sum,
    output logic           bad
);
    import pc_pkg::*;

    logic [AW-1:0] acc;

    always_comb begin
        acc = AW'(fl);
        bad = 1'b0;
        for (int i = 0; i < K; i++) begin
            acc = acc + (AW'(dig[2*i +: 2]) << (OW - 2 - i));
            bad = bad | dig_is_bad(dig[2*i +: 2]);
        end
        if (acc > AW'({OW{1'b1}})) begin
            sum = {OW{1'b1}};
        end else begin
            sum = acc[OW-1:0];
        end
    end
endmodule

// File: rtl/pipe_corr.sv
module pipe_corr #(
    parameter int NSTG = 6,
    parameter int FLW  = 2,
    localparam int OW  = NSTG + FLW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [2*NSTG-1:0] stg_dig,
    input  logic [FLW-1:0]  fl_code,
    output logic            out_vld,
    output logic [OW-1:0]   out_code,
    output logic            out_bad
);
    typedef struct packed {
        logic          vld;
        logic          bad;
        logic [OW-1:0] code;
    } res_t;

    logic [2*NSTG-1:0] dig_al;
    logic              vld_al;
    logic [OW-1:0]     sum;
    logic              sum_bad;
    res_t              res_d, res_q;

    // Stage i waits NSTG-i edges so all digits of a sample meet the flash code.
    for (genvar i = 0; i < NSTG; i++) begin : g_align
        pc_delay #(.W(2), .DEPTH(NSTG - i)) u_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (stg_dig[2*i +: 2]),
            .dout (dig_al[2*i +: 2])
        );
    end

    pc_delay #(.W(1), .DEPTH(NSTG)) u_vdly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (in_vld),
        .dout (vld_al)
    );

    pc_sum #(.K(NSTG), .FW(FLW)) u_sum (
        .dig(dig_al),
        .fl (fl_code),
        .sum(sum),
        .bad(sum_bad)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = vld_al;
        res_d.bad = vld_al & sum_bad;
        if (vld_al) begin
            res_d.code = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_vld  = res_q.vld;
    assign out_bad  = res_q.bad;
    assign out_code = res_q.code;
endmodule

// File: rtl/pc_chk.sv
module pc_chk #(
    parameter int K  = 6,
    parameter int OW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_vld,
    input logic [1:0]    dig0,
    input logic          out_vld,
    input logic          out_bad,
    input logic [OW-1:0] out_code
);
    logic [K:0] vpipe;
    logic [K:0] bpipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpipe <= '0;
            bpipe <= '0;
        end else begin
            vpipe <= {vpipe[K-1:0], in_vld};
            bpipe <= {bpipe[K-1:0], in_vld && (dig0 == 2'b11)};
        end
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == vpipe[K]);

    a_r6_stage0_flag: assert property (@(posedge clk) disable iff (!rst_n)
        bpipe[K] |-> out_bad);

    a_r8_bad_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad |-> out_vld);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(out_code));
endmodule

bind pipe_corr pc_chk #(.K(NSTG), .OW(OW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .dig0    (stg_dig[1:0]),
    .out_vld (out_vld),
    .out_bad (out_bad),
    .out_code(out_code)
);

// File: tb/sim_pipe_corr.sv
module sim_pipe_corr;
    localparam int CLK_P = 10;
    localparam int NSTG  = 6;
    localparam int FLW   = 2;
    localparam int OW    = NSTG + FLW;
    localparam int M     = OW + 4;
    localparam int VREF  = 1 << M;
    localparam int NS    = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic [2*NSTG-1:0] stg_dig = '0;
    logic [FLW-1:0]    fl_code = '0;
    logic              out_vld;
    logic [OW-1:0]     out_code;
    logic              out_bad;

    pipe_corr #(.NSTG(NSTG), .FLW(FLW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .stg_dig(stg_dig),
        .fl_code(fl_code), .out_vld(out_vld), .out_code(out_code), .out_bad(out_bad)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int last_code = 0;

    logic              s_vld [NS];
    logic [2*NSTG-1:0] s_dig [NS];
    int                s_fl  [NS];
    int                s_exp [NS];
    logic              s_bad [NS];

    task automatic chk(input string tg, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Behavioural 1.5-bit stages; thresholds moved towards mid-scale by off.
    task automatic model(input int vin, input int off,
                         output logic [2*NSTG-1:0] dg, output int fl);
        int r = vin;
        for (int i = 0; i < NSTG; i++) begin
            if (r >= VREF/4 - off) begin
                dg[2*i +: 2] = 2'b10; r = 2*r - VREF;
            end else if (r < -VREF/4 + off) begin
                dg[2*i +: 2] = 2'b00; r = 2*r + VREF;
            end else begin
                dg[2*i +: 2] = 2'b01; r = 2*r;
            end
        end
        fl = (r + VREF) / (VREF/2);
        if (fl > 3) fl = 3;
        if (fl < 0) fl = 0;
    endtask

    function automatic int ideal(input int vin);
        return (vin + VREF) >> (M + 1 - OW);
    endfunction

    task automatic run_stream(input int n, input string tg);
        logic [2*NSTG-1:0] dv;
        int j;
        for (int c = 0; c < n + NSTG + 1; c++) begin
            @(negedge clk);
            j = c - 1 - NSTG;
            if (j >= 0 && j < n) begin
                chk("R2 out_vld", int'(out_vld), int'(s_vld[j]));
                if (s_vld[j]) begin
                    chk(tg, int'(out_code), s_exp[j]);
                    chk("R6 out_bad", int'(out_bad), int'(s_bad[j]));
                    last_code = s_exp[j];
                end else begin
                    chk("R8 held code", int'(out_code), last_code);
                    chk("R8 bad idle", int'(out_bad), 0);
                end
            end
            in_vld = (c < n) ? s_vld[c] : 1'b0;
            for (int i = 0; i < NSTG; i++) begin
                j = c - i;
                dv[2*i +: 2] = (j >= 0 && j < n && s_vld[j]) ? s_dig[j][2*i +: 2] : 2'b01;
            end
            stg_dig = dv;
            j = c - NSTG;
            fl_code = (j >= 0 && j < n && s_vld[j]) ? FLW'(s_fl[j]) : '0;
        end
    endtask

    task automatic fill_sweep(input int off, input int gap);
        for (int s = 0; s < NS; s++) begin
            int vin = -VREF + 2*s;
            s_vld[s] = !(gap != 0 && (s % gap) == gap - 1);
            model(vin, off, s_dig[s], s_fl[s]);
            s_exp[s] = ideal(vin);
            s_bad[s] = 1'b0;
        end
    endtask

    // Weighted sum straight from the digit definition, clamped.
    function automatic int wsum(input logic [2*NSTG-1:0] dg, input int fl);
        int a = fl;
        for (int i = 0; i < NSTG; i++) a += int'(dg[2*i +: 2]) * (1 << (OW - 2 - i));
        if (a > (1 << OW) - 1) a = (1 << OW) - 1;
        return a;
    endfunction

    task automatic put(input int k, input logic [2*NSTG-1:0] dg, input int fl, input logic bd);
        s_vld[k] = 1'b1; s_dig[k] = dg; s_fl[k] = fl; s_bad[k] = bd;
        s_exp[k] = wsum(dg, fl);
    endtask

    initial begin
        int k;
        logic [2*NSTG-1:0] dg;
        repeat (3) @(negedge clk);
        chk("R1 vld in reset", int'(out_vld), 0);
        chk("R1 code in reset", int'(out_code), 0);
        chk("R1 bad in reset", int'(out_bad), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vld after reset", int'(out_vld), 0);
        chk("R1 code after reset", int'(out_code), 0);

        fill_sweep(0, 0);
        run_stream(NS, "R3 ideal sweep");
        fill_sweep(900, 3);
        run_stream(NS, "R5 inward offset");
        fill_sweep(-900, 5);
        run_stream(NS, "R5 outward offset");

        k = 0;
        put(k, {NSTG{2'b10}}, 3, 1'b0); k++;
        put(k, {NSTG{2'b00}}, 0, 1'b0); k++;
        for (int i = 0; i < NSTG; i++) begin
            dg = {NSTG{2'b00}};
            dg[2*i +: 2] = 2'b10;
            put(k, dg, 0, 1'b0); k++;
            dg[2*i +: 2] = 2'b01;
            put(k, dg, 1, 1'b0); k++;
        end
        dg = {NSTG{2'b10}}; dg[1:0] = 2'b11;
        put(k, dg, 3, 1'b1); k++;
        dg = {NSTG{2'b00}}; dg[2*NSTG-1 -: 2] = 2'b11;
        put(k, dg, 0, 1'b1); k++;
        s_vld[k] = 1'b0; s_dig[k] = '0; s_fl[k] = 0; s_bad[k] = 1'b0; s_exp[k] = 0; k++;
        run_stream(k, "R4 R7 direct digits");

        @(negedge clk);
        chk("R7 clamp all ones", wsum({NSTG{2'b11}}, 3), (1 << OW) - 1);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
        summary();
    end
endmodule